// File: doc/BRIEF.md
# Multi-Bank Endpoint Status Tracker

This block follows the buffer-bank state of one USB device endpoint that runs with one, two or three ping-pong banks. It reports which bank firmware is working on now and how many banks hold data. For an IN endpoint these are banks filled by firmware and waiting to go to the host. For an OUT endpoint they are banks filled by the host and waiting for firmware. It also reports the byte count of the bank being accessed and a sticky flag raised when a NAK went out for an OUT or PING token. When the endpoint is set up as a control endpoint, the bank field is reused to report the direction of the control transfer, taken from the last setup packet.

The block receives single-cycle event strobes. Firmware events are packet ready, OUT bank released, byte written and byte read. Protocol-engine events are OUT packet received together with its length, IN packet sent, NAK sent and setup received. An endpoint reset strobe and an endpoint disable strobe both return every status field to zero. All status outputs are registered and change on the clock edge that follows the event.

Top module: `ept_bank_tracker`

## Requirements
- R1: `cur_bank` encodes the current bank as 0, 1 or 2 and never shows 3. The index wraps modulo the effective bank count. The effective count is 1 when `cfg_nbanks` is 0 or 1, 2 when it is 2 and 3 when it is 3. With one bank the index stays 0.
- R2: In IN mode (`cfg_in`=1), an accepted `fw_pkt_rdy` moves `cur_bank` to the next bank, raises `busy_banks` by one and clears `byte_count` to 0. `pe_in_sent` lowers `busy_banks` by one.
- R3: In OUT mode (`cfg_in`=0), an accepted `pe_out_rcv` raises `busy_banks` by one. An accepted `fw_out_clr` moves `cur_bank` to the next bank and lowers `busy_banks` by one.
- R4: `busy_banks` holds the number of busy banks, from 0 to the effective count. A fill event (`fw_pkt_rdy` in IN mode, `pe_out_rcv` in OUT mode) arriving while all banks are busy is ignored, unless a release is accepted in the same cycle. A release (`pe_in_sent` or `fw_out_clr`) arriving while no bank is busy is ignored. A fill and a release accepted together leave the count unchanged.
- R5: When no load event occurs, `fw_wr` raises `byte_count` by one and `fw_rd` lowers it by one. The count holds at its maximum 2^BC_W-1 and at 0. Both strobes in the same cycle leave it unchanged.
- R6: In OUT mode, `byte_count` is loaded with the length of the packet that was received into the bank that becomes current. This happens when a packet lands in an empty endpoint and when a release leaves data behind. If a release leaves no busy bank, `byte_count` becomes 0. A load takes priority over `fw_wr` and `fw_rd`.
- R7: `pe_nak` sets `nak_out`, which stays set until an endpoint reset or disable.
- R8: With `cfg_ctrl`=1, the effective count is 1 and `cur_bank` shows {0, d}. Here d is the `setup_req_dir` value (bit 7 of byte 0 of the setup data) captured at the last `pe_setup`, and it starts at 0. The value 0 means a control write and 1 means a control read.
- R9: `rst`, `ep_rst` or `ep_dis` clears `cur_bank`, `busy_banks`, `byte_count`, `nak_out` and the control direction on the next edge, taking priority over any event in the same cycle.
- R10: Events of the other direction have no effect: `pe_out_rcv` and `fw_out_clr` in IN mode, `fw_pkt_rdy` and `pe_in_sent` in OUT mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_ctrl | input | 1 | 1 = control endpoint |
| cfg_nbanks | input | 2 | Configured bank count (0 treated as 1) |
| fw_pkt_rdy | input | 1 | Firmware: IN bank filled and handed off |
| fw_out_clr | input | 1 | Firmware: OUT bank released |
| fw_wr | input | 1 | Firmware: one byte written |
| fw_rd | input | 1 | Firmware: one byte read |
| pe_out_rcv | input | 1 | Engine: OUT packet stored in a bank |
| pe_out_len | input | BC_W | Length of the received OUT packet |
| pe_in_sent | input | 1 | Engine: IN bank transmitted |
| pe_nak | input | 1 | Engine: NAK sent for OUT or PING |
| pe_setup | input | 1 | Engine: new setup data received |
| setup_req_dir | input | 1 | Bit 7 of setup byte 0 |
| ep_rst | input | 1 | Endpoint reset strobe |
| ep_dis | input | 1 | Endpoint disable strobe |
| cur_bank | output | 2 | Current bank, or control direction |
| busy_banks | output | 2 | Number of busy banks |
| byte_count | output | BC_W | Byte count of the accessed bank |
| nak_out | output | 1 | NAK-sent flag |

## Verification
The hardest case to reach is an OUT endpoint with every bank full when the host packet and the firmware release arrive in the same cycle. The new length must land in the bank being freed, and the next bank's stored length must appear, with the write position wrapped past the last bank. The stimulus first fills all three banks with distinct lengths, then strobes receive and release together several times. The returned byte counts therefore show whether the lengths come back in arrival order. The single-bank variant of the same collision, where the new length must pass straight through to the count, is driven after a reconfiguration to one bank.

// File: rtl/ept_pkg.sv
package ept_pkg;
  localparam int IDX_W = 2;
  typedef logic [IDX_W-1:0] idx_t;

  // next index, wrapping at n
  function automatic idx_t idx_wrap_inc(idx_t i, idx_t n);
    logic [IDX_W:0] s;
    s = {1'b0, i} + 1'b1;
    return (s >= {1'b0, n}) ? '0 : s[IDX_W-1:0];
  endfunction

  // (a + b) mod n for a < n, b <= n
  function automatic idx_t idx_add_mod(idx_t a, idx_t b, idx_t n);
    logic [IDX_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, n}) s = s - {1'b0, n};
    return s[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/ept_bank_ctl.sv
module ept_bank_ctl
  import ept_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  idx_t n_eff,
  input  logic req_fill,
  input  logic req_free,
  input  logic adv_on_fill,
  output logic fill_ok,
  output logic free_ok,
  output idx_t cur_q,
  output idx_t busy_q,
  output idx_t cur_nxt,
  output idx_t busy_nxt,
  output idx_t wptr
);
  logic adv;

  assign free_ok = req_free && (busy_q != '0);
  assign fill_ok = req_fill && ((busy_q < n_eff) || free_ok);
  assign adv     = adv_on_fill ? fill_ok : free_ok;
  assign cur_nxt = adv ? idx_wrap_inc(cur_q, n_eff) : cur_q;
  assign wptr    = idx_add_mod(cur_q, busy_q, n_eff);

  always_comb begin
    case ({fill_ok, free_ok})
      2'b10:   busy_nxt = busy_q + 1'b1;
      2'b01:   busy_nxt = busy_q - 1'b1;
      default: busy_nxt = busy_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cur_q  <= '0;
      busy_q <= '0;
    end else begin
      cur_q  <= cur_nxt;
      busy_q <= busy_nxt;
    end
  end
endmodule

// File: rtl/ept_len_store.sv
module ept_len_store
  import ept_pkg::*;
#(
  parameter int NB    = 3,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             we,
  input  idx_t             waddr,
  input  logic [LEN_W-1:0] wdata,
  input  idx_t             raddr,
  output logic [LEN_W-1:0] rdata
);
  logic [LEN_W-1:0] bank_len [NB];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [LEN_W-1:0] len_q;
    always_ff @(posedge clk) begin
      if (we && (waddr == idx_t'(g))) len_q <= wdata;
    end
    assign bank_len[g] = len_q;
  end

  // read with write-through so a same-cycle store is visible
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NB; i++) begin
      if (raddr == idx_t'(i)) rdata = bank_len[i];
    end
    if (we && (waddr == raddr)) rdata = wdata;
  end
endmodule

// File: rtl/ept_byte_cnt.sv
module ept_byte_cnt #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (inc && !dec) begin
      if (count != CMAX) count <= count + 1'b1;
    end else if (dec && !inc) begin
      if (count != '0) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/ept_bank_tracker.sv
module ept_bank_tracker
  import ept_pkg::*;
#(
  parameter int MAX_BANKS = 3,
  parameter int BC_W      = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_in,
  input  logic            cfg_ctrl,
  input  logic [1:0]      cfg_nbanks,
  input  logic            fw_pkt_rdy,
  input  logic            fw_out_clr,
  input  logic            fw_wr,
  input  logic            fw_rd,
  input  logic            pe_out_rcv,
  input  logic [BC_W-1:0] pe_out_len,
  input  logic            pe_in_sent,
  input  logic            pe_nak,
  input  logic            pe_setup,
  input  logic            setup_req_dir,
  input  logic            ep_rst,
  input  logic            ep_dis,
  output logic [1:0]      cur_bank,
  output logic [1:0]      busy_banks,
  output logic [BC_W-1:0] byte_count,
  output logic            nak_out
);
  localparam idx_t MAXB = idx_t'(MAX_BANKS);

  logic clr;
  idx_t n_eff;
  logic fill_ok, free_ok;
  idx_t cur_q, busy_q, cur_nxt, busy_nxt, wptr;
  logic [BC_W-1:0] len_rd;
  logic len_we;
  logic bc_load;
  logic [BC_W-1:0] bc_val;
  logic dir_q, dir_nxt;

  assign clr = ep_rst || ep_dis;

  always_comb begin
    if (cfg_ctrl || (cfg_nbanks == 2'd0)) n_eff = idx_t'(1);
    else if (cfg_nbanks > MAXB)           n_eff = MAXB;
    else                                  n_eff = cfg_nbanks;
  end

  ept_bank_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .clr         (clr),
    .n_eff       (n_eff),
    .req_fill    (cfg_in ? fw_pkt_rdy : pe_out_rcv),
    .req_free    (cfg_in ? pe_in_sent : fw_out_clr),
    .adv_on_fill (cfg_in),
    .fill_ok     (fill_ok),
    .free_ok     (free_ok),
    .cur_q       (cur_q),
    .busy_q      (busy_q),
    .cur_nxt     (cur_nxt),
    .busy_nxt    (busy_nxt),
    .wptr        (wptr)
  );

  assign len_we = !cfg_in && fill_ok && !clr && !rst;

  ept_len_store #(.NB(MAX_BANKS), .LEN_W(BC_W)) u_len (
    .clk   (clk),
    .we    (len_we),
    .waddr (wptr),
    .wdata (pe_out_len),
    .raddr (cur_nxt),
    .rdata (len_rd)
  );

  always_comb begin
    bc_load = 1'b0;
    bc_val  = '0;
    if (cfg_in) begin
      bc_load = fill_ok;
    end else if (free_ok) begin
      bc_load = 1'b1;
      bc_val  = (busy_nxt == '0) ? '0 : len_rd;
    end else if (fill_ok && (busy_q == '0)) begin
      bc_load = 1'b1;
      bc_val  = len_rd;
    end
  end

  ept_byte_cnt #(.W(BC_W)) u_bc (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .load     (bc_load),
    .load_val (bc_val),
    .inc      (fw_wr),
    .dec      (fw_rd),
    .count    (byte_count)
  );

  assign dir_nxt = (cfg_ctrl && pe_setup) ? setup_req_dir : dir_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dir_q    <= 1'b0;
      nak_out  <= 1'b0;
      cur_bank <= '0;
    end else begin
      dir_q    <= dir_nxt;
      if (pe_nak) nak_out <= 1'b1;
      cur_bank <= cfg_ctrl ? {1'b0, dir_nxt} : cur_nxt;
    end
  end

  assign busy_banks = busy_q;
endmodule

// File: rtl/ept_bank_tracker_chk.sv
module ept_bank_tracker_chk #(
  parameter int BC_W = 11
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_in,
  input logic            cfg_ctrl,
  input logic            fw_pkt_rdy,
  input logic            pe_nak,
  input logic            pe_setup,
  input logic            setup_req_dir,
  input logic            ep_rst,
  input logic            ep_dis,
  input logic [1:0]      cur_bank,
  input logic [1:0]      busy_banks,
  input logic [BC_W-1:0] byte_count,
  input logic            nak_out
);
  p_bank_code_r1: assert property (@(posedge clk) disable iff (rst)
    !(ep_rst || ep_dis) |=> (cur_bank != 2'b11));

  p_in_ready_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_in && fw_pkt_rdy && (busy_banks == 2'd0) && !ep_rst && !ep_dis)
      |=> (byte_count == '0) && (busy_banks == 2'd1));

  p_busy_step_r4: assert property (@(posedge clk) disable iff (rst)
    !(ep_rst || ep_dis) |=> ((busy_banks == $past(busy_banks)) ||
                             (busy_banks == $past(busy_banks) + 2'd1) ||
                             (busy_banks + 2'd1 == $past(busy_banks))));

  p_nak_set_r7: assert property (@(posedge clk) disable iff (rst)
    (pe_nak && !ep_rst && !ep_dis) |=> nak_out);

  p_nak_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (nak_out && !ep_rst && !ep_dis) |=> nak_out);

  p_setup_dir_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_ctrl && pe_setup && !ep_rst && !ep_dis)
      |=> (cur_bank == {1'b0, $past(setup_req_dir)}));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (ep_rst || ep_dis) |=> ((cur_bank == 2'd0) && (busy_banks == 2'd0) &&
                            (byte_count == '0) && !nak_out));
endmodule

bind ept_bank_tracker ept_bank_tracker_chk #(.BC_W(BC_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_in        (cfg_in),
  .cfg_ctrl      (cfg_ctrl),
  .fw_pkt_rdy    (fw_pkt_rdy),
  .pe_nak        (pe_nak),
  .pe_setup      (pe_setup),
  .setup_req_dir (setup_req_dir),
  .ep_rst        (ep_rst),
  .ep_dis        (ep_dis),
  .cur_bank      (cur_bank),
  .busy_banks    (busy_banks),
  .byte_count    (byte_count),
  .nak_out       (nak_out)
);

// File: tb/tb_ept_bank_tracker.sv
`timescale 1ns/1ps
module tb_ept_bank_tracker;
  localparam int BC_W = 11;
  localparam int BCMAX = (1 << BC_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_in = 1'b1, cfg_ctrl = 1'b0;
  logic [1:0] cfg_nbanks = 2'd3;
  logic fw_pkt_rdy = 0, fw_out_clr = 0, fw_wr = 0, fw_rd = 0;
  logic pe_out_rcv = 0, pe_in_sent = 0, pe_nak = 0, pe_setup = 0;
  logic setup_req_dir = 0, ep_rst = 0, ep_dis = 0;
  logic [BC_W-1:0] pe_out_len = '0;
  logic [1:0] cur_bank, busy_banks;
  logic [BC_W-1:0] byte_count;
  logic nak_out;

  always #5 clk = ~clk;

  ept_bank_tracker #(.MAX_BANKS(3), .BC_W(BC_W)) dut (
    .clk(clk), .rst(rst), .cfg_in(cfg_in), .cfg_ctrl(cfg_ctrl),
    .cfg_nbanks(cfg_nbanks), .fw_pkt_rdy(fw_pkt_rdy), .fw_out_clr(fw_out_clr),
    .fw_wr(fw_wr), .fw_rd(fw_rd), .pe_out_rcv(pe_out_rcv),
    .pe_out_len(pe_out_len), .pe_in_sent(pe_in_sent), .pe_nak(pe_nak),
    .pe_setup(pe_setup), .setup_req_dir(setup_req_dir), .ep_rst(ep_rst),
    .ep_dis(ep_dis), .cur_bank(cur_bank), .busy_banks(busy_banks),
    .byte_count(byte_count), .nak_out(nak_out)
  );

  typedef struct packed {
    logic [1:0]      cur;
    logic [1:0]      busy;
    logic [BC_W-1:0] bc;
    logic            nak;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state
  int m_cur = 0, m_busy = 0, m_bc = 0;
  bit m_nak = 0, m_dir = 0;
  int len_q[$];

  // monitor: compares one expectation after every rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (cur_bank !== e.cur || busy_banks !== e.busy ||
          byte_count !== e.bc || nak_out !== e.nak) begin
        n_bad++;
        $display("FAIL %s: cur=%0d busy=%0d bc=%0d nak=%0b exp cur=%0d busy=%0d bc=%0d nak=%0b",
                 t, cur_bank, busy_banks, byte_count, nak_out,
                 e.cur, e.busy, e.bc, e.nak);
      end
    end
  end

  // driver: model the cycle, queue expectation, advance one clock
  task automatic step(input string tag);
    int n;
    bit loaded;
    exp_t e;
    n = cfg_ctrl ? 1 : ((cfg_nbanks == 0) ? 1 : int'(cfg_nbanks));
    loaded = 0;
    if (rst || ep_rst || ep_dis) begin
      m_cur = 0; m_busy = 0; m_bc = 0; m_nak = 0; m_dir = 0;
      len_q.delete();
    end else begin
      if (pe_nak) m_nak = 1;
      if (cfg_ctrl && pe_setup) m_dir = setup_req_dir;
      if (cfg_in) begin
        bit sent_ok, rdy_ok;
        sent_ok = pe_in_sent && (m_busy > 0);
        rdy_ok  = fw_pkt_rdy && ((m_busy < n) || sent_ok);
        if (rdy_ok) begin
          m_cur = (m_cur + 1) % n;
          m_bc = 0;
          loaded = 1;
        end
        m_busy = m_busy + int'(rdy_ok) - int'(sent_ok);
      end else begin
        bit clr_ok, rcv_ok;
        int old;
        old = len_q.size();
        clr_ok = fw_out_clr && (old > 0);
        rcv_ok = pe_out_rcv && ((old < n) || clr_ok);
        if (clr_ok) begin
          void'(len_q.pop_front());
          m_cur = (m_cur + 1) % n;
        end
        if (rcv_ok) len_q.push_back(int'(pe_out_len));
        m_busy = len_q.size();
        if (clr_ok) begin
          m_bc = (len_q.size() > 0) ? len_q[0] : 0;
          loaded = 1;
        end else if (rcv_ok && old == 0) begin
          m_bc = len_q[0];
          loaded = 1;
        end
      end
      if (!loaded) begin
        if (fw_wr && !fw_rd && m_bc < BCMAX) m_bc++;
        else if (fw_rd && !fw_wr && m_bc > 0) m_bc--;
      end
    end
    e.cur  = cfg_ctrl ? {1'b0, m_dir} : 2'(m_cur);
    e.busy = 2'(m_busy);
    e.bc   = BC_W'(m_bc);
    e.nak  = m_nak;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    fw_pkt_rdy = 0; fw_out_clr = 0; fw_wr = 0; fw_rd = 0;
    pe_out_rcv = 0; pe_in_sent = 0; pe_nak = 0; pe_setup = 0;
    ep_rst = 0; ep_dis = 0;
  endtask

  task automatic reconfig(input bit in_m, input bit ctrl_m, input logic [1:0] nb);
    cfg_in = in_m; cfg_ctrl = ctrl_m; cfg_nbanks = nb;
    ep_rst = 1;
    step("R9 reconfig");
  endtask

  task automatic out_rcv(input int len, input string tag);
    pe_out_rcv = 1; pe_out_len = BC_W'(len);
    step(tag);
  endtask

  initial begin
    @(negedge clk);
    step("R9 reset");
    step("R9 reset");
    rst = 0;
    step("R9 idle after reset");

    // IN, three banks
    reconfig(1, 0, 2'd3);
    for (int i = 0; i < 5; i++) begin fw_wr = 1; step("R5 write"); end
    fw_pkt_rdy = 1; step("R2 ready 1");
    fw_wr = 1; step("R5 write");
    fw_pkt_rdy = 1; step("R2 ready 2");
    fw_pkt_rdy = 1; step("R1 ready wraps");
    fw_wr = 1; step("R5 write");
    fw_pkt_rdy = 1; step("R4 ready when full ignored");
    fw_pkt_rdy = 1; pe_in_sent = 1; step("R4 ready+sent at full");
    pe_in_sent = 1; step("R2 sent");
    pe_out_rcv = 1; pe_out_len = 11'd9; step("R10 rcv in IN mode");
    fw_out_clr = 1; step("R10 clr in IN mode");
    pe_in_sent = 1; step("R2 sent");
    pe_in_sent = 1; step("R2 sent");
    pe_in_sent = 1; step("R4 sent at zero ignored");

    // byte count limits
    fw_rd = 1; step("R5 read at zero holds");
    for (int i = 0; i < BCMAX + 3; i++) begin fw_wr = 1; step("R5 write to max"); end
    fw_wr = 1; fw_rd = 1; step("R5 write+read hold");
    fw_rd = 1; step("R5 read");

    // NAK flag
    pe_nak = 1; step("R7 nak set");
    step("R7 nak holds");
    ep_dis = 1; step("R9 disable clears nak");

    // OUT, two banks
    reconfig(0, 0, 2'd2);
    fw_pkt_rdy = 1; step("R10 ready in OUT mode");
    pe_in_sent = 1; step("R10 sent in OUT mode");
    out_rcv(10, "R6 first packet loads");
    out_rcv(20, "R3 second packet");
    out_rcv(30, "R4 rcv when full ignored");
    for (int i = 0; i < 3; i++) begin fw_rd = 1; step("R5 read"); end
    fw_out_clr = 1; fw_rd = 1; step("R6 release loads next, beats read");
    fw_out_clr = 1; step("R6 release to empty");
    fw_out_clr = 1; step("R4 release at zero ignored");

    // OUT, three banks, collisions at full
    reconfig(0, 0, 2'd3);
    out_rcv(100, "R6 load 100");
    out_rcv(200, "R3 fill");
    out_rcv(300, "R3 fill");
    for (int k = 0; k < 4; k++) begin
      fw_out_clr = 1; pe_out_rcv = 1; pe_out_len = BC_W'(400 + k);
      step("R6 rcv+release at full");
    end
    fw_out_clr = 1; step("R3 release");
    fw_out_clr = 1; step("R3 release");
    fw_out_clr = 1; step("R6 release to empty");

    // OUT, single bank, collision bypass
    reconfig(0, 0, 2'd1);
    out_rcv(7, "R6 single load");
    fw_out_clr = 1; pe_out_rcv = 1; pe_out_len = 11'd13;
    step("R6 single rcv+release");
    fw_out_clr = 1; step("R1 single stays 0");

    // zero bank count acts as one
    reconfig(1, 0, 2'd0);
    fw_pkt_rdy = 1; step("R1 nb0 ready");
    fw_pkt_rdy = 1; step("R1 nb0 full");

    // control endpoint
    reconfig(0, 1, 2'd3);
    pe_setup = 1; setup_req_dir = 1; step("R8 control read");
    out_rcv(8, "R8 rcv keeps direction");
    fw_out_clr = 1; step("R8 release keeps direction");
    pe_setup = 1; setup_req_dir = 0; step("R8 control write");
    pe_setup = 1; setup_req_dir = 1; step("R8 control read again");
    cfg_ctrl = 0; pe_setup = 1; setup_req_dir = 0; step("R8 setup ignored off control");

    // reset priority over events
    reconfig(1, 0, 2'd2);
    fw_pkt_rdy = 1; pe_nak = 1; step("R2 ready");
    ep_rst = 1; fw_pkt_rdy = 1; pe_nak = 1; fw_wr = 1; step("R9 reset beats events");

    step("drain");
    step("drain");
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule